// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Chain

This block divides a fast input clock by a programmable integer and issues one short pulse per division cycle, meant as the feedback input of a phase detector. A prescaler counts either ten or eleven input clocks per prescaler cycle. A swallow count picks which of the two it uses: the first `swallowA` prescaler cycles of each division cycle use eleven clocks and the rest use ten. A main counter ends the division cycle after `divM + 1` prescaler cycles. The total ratio is therefore 10 x (M + 1) + A. M is legal from 1 to 511, and A must be no larger than M + 1.

When `bypassPre` is high, the prescaler and the swallow path are idle and the input clock is divided by M + 1 alone. When `directMode` is high, the two upper bits of M are treated as zero. The usable M range is then 1 to 127.

The whole chain is synchronous logic on the input clock. The divisor settings are taken in only on the first clock of each division cycle. A host may therefore change them at any time without disturbing a cycle that is already running.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rstN` is low, `fpOut` is low. The first rising edge after reset release is clock 1 of the first division cycle. `fpOut` is then high after rising edge N, where N is the ratio for the settings present at that first edge.
- R2: With `bypassPre` low, consecutive `fpOut` pulses are exactly 10 x (M + 1) + A input clocks apart.
- R3: The first A prescaler cycles of each division cycle last 11 clocks and the rest last 10. As a result, A = 0 gives 10 x (M + 1) and A = M + 1 gives 11 x (M + 1).
- R4: With `bypassPre` high, consecutive pulses are M + 1 input clocks apart.
- R5: M = 1 gives the smallest ratios. In bypass the period is 2. With the prescaler active it is 20 + A.
- R6: With `directMode` high, bits 8 and 7 of `divM` are taken as zero, so M is `divM[6:0]`.
- R7: Each `fpOut` pulse is high for exactly one input clock.
- R8: `divM`, `swallowA`, `bypassPre` and `directMode` are sampled only on the first clock of a division cycle, which is the edge after a pulse. A change in mid-cycle leaves the length of the running cycle unchanged.
- R9: In bypass mode the value of `swallowA` has no effect on the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rstN | input | 1 | Asynchronous reset, active low |
| divM | input | 9 | Main counter setting M |
| swallowA | input | 4 | Swallow count A, the number of eleven-clock prescaler cycles |
| bypassPre | input | 1 | High: skip the prescaler and divide by M + 1 |
| directMode | input | 1 | High: force M bits 8 and 7 to zero |
| fpOut | output | 1 | One-clock pulse at the end of each division cycle |

## Verification
Any error in the prescaler count, the swallow count or the main count moves the next `fpOut` pulse. The per-clock comparison against the behavioural model therefore flags a wrong internal state no later than the end of the division cycle it occurs in. That is at most a few thousand clocks. A settings latch that samples at the wrong time shows up in the cycle that follows a mid-cycle change, because that cycle's length takes the wrong value. A masking fault in direct mode makes the period of every cycle wrong.

// File: rtl/divider_pkg.sv
package divider_pkg;

  // Strobes from the cycle control to the counter datapath
  typedef struct packed {
    logic load;    // this clock starts a new division cycle
    logic bypass;  // prescaler bypassed for this clock
    logic eleven;  // prescaler cycle in progress uses the longer modulus
  } divStrobe_t;

endpackage

// File: rtl/div_datapath.sv
module div_datapath
  import divider_pkg::*;
#(
  parameter int M_WIDTH       = 9,
  parameter int PRESCALE_LOW  = 10,
  parameter int DIRECT_M_BITS = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         stb,
  input  logic [M_WIDTH-1:0] divM,
  input  logic               directMode,
  output logic               preDone,
  output logic               lastTick
);

  localparam int PRESCALE_HIGH = PRESCALE_LOW + 1;
  localparam int PW = $clog2(PRESCALE_HIGH + 1);
  localparam logic [PW-1:0] LAST_LOW  = PW'(PRESCALE_LOW - 1);
  localparam logic [PW-1:0] LAST_HIGH = PW'(PRESCALE_HIGH - 1);

  logic [M_WIDTH-1:0] mLatched, mBase, maskedM;
  logic [M_WIDTH-1:0] mainCnt, mainBase;
  logic [PW-1:0]      preCnt, preBase, preLast;

  generate
    if (DIRECT_M_BITS < M_WIDTH) begin : g_mask
      assign maskedM = directMode
                     ? {{(M_WIDTH-DIRECT_M_BITS){1'b0}}, divM[DIRECT_M_BITS-1:0]}
                     : divM;
    end else begin : g_nomask
      assign maskedM = divM;
    end
  endgenerate

  always_comb begin
    mBase    = stb.load ? maskedM : mLatched;
    preBase  = stb.load ? '0 : preCnt;
    mainBase = stb.load ? '0 : mainCnt;
    if (stb.bypass)      preLast = '0;
    else if (stb.eleven) preLast = LAST_HIGH;
    else                 preLast = LAST_LOW;
    preDone  = (preBase == preLast);
    lastTick = (mainBase == mBase);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLatched <= '0;
      preCnt   <= '0;
      mainCnt  <= '0;
    end else begin
      mLatched <= mBase;
      preCnt   <= preDone ? '0 : preBase + 1'b1;
      if (preDone && !lastTick) mainCnt <= mainBase + 1'b1;
      else                      mainCnt <= mainBase;
    end
  end

  assert_pre_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= LAST_HIGH);

  assert_main_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    mainCnt <= mLatched);

  assert_bypass_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bypass && !stb.load) |-> (preCnt == '0));

  assert_hold_settings_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(mLatched));

  generate
    if (DIRECT_M_BITS < M_WIDTH) begin : g_mask_check
      assert_direct_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
        (stb.load && directMode) |=> (mLatched[M_WIDTH-1:DIRECT_M_BITS] == '0));
    end
  endgenerate

endmodule

// File: rtl/div_control.sv
module div_control
  import divider_pkg::*;
#(
  parameter int A_WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [A_WIDTH-1:0] swallowA,
  input  logic               bypassPre,
  input  logic               preDone,
  input  logic               lastTick,
  output divStrobe_t         stb,
  output logic               fpOut
);

  logic               needLoad, fpReg, bypLatched;
  logic [A_WIDTH-1:0] aLatched, aBase, swCnt, swBase;
  logic               load, bypBase, eleven;

  always_comb begin
    load    = needLoad | fpReg;
    aBase   = load ? swallowA : aLatched;
    bypBase = load ? bypassPre : bypLatched;
    swBase  = load ? '0 : swCnt;
    eleven  = !bypBase && (swBase < aBase);
    stb.load   = load;
    stb.bypass = bypBase;
    stb.eleven = eleven;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      needLoad   <= 1'b1;
      fpReg      <= 1'b0;
      aLatched   <= '0;
      bypLatched <= 1'b0;
      swCnt      <= '0;
    end else begin
      needLoad   <= 1'b0;
      fpReg      <= preDone & lastTick;
      aLatched   <= aBase;
      bypLatched <= bypBase;
      swCnt      <= swBase + A_WIDTH'(preDone & eleven);
    end
  end

  assign fpOut = fpReg;

  assert_swallow_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    swCnt <= aLatched);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fpReg && !bypLatched) |=> !fpReg);

  assert_quiet_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    needLoad |-> !fpReg);

  assert_no_swallow_bypass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bypLatched && !load) |-> (swCnt == '0));

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import divider_pkg::*;
#(
  parameter int M_WIDTH       = 9,
  parameter int A_WIDTH       = 4,
  parameter int PRESCALE_LOW  = 10,
  parameter int DIRECT_M_BITS = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [M_WIDTH-1:0] divM,
  input  logic [A_WIDTH-1:0] swallowA,
  input  logic               bypassPre,
  input  logic               directMode,
  output logic               fpOut
);

  divStrobe_t stb;
  logic       preDone, lastTick;

  div_control #(.A_WIDTH(A_WIDTH)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .swallowA (swallowA),
    .bypassPre(bypassPre),
    .preDone  (preDone),
    .lastTick (lastTick),
    .stb      (stb),
    .fpOut    (fpOut)
  );

  div_datapath #(
    .M_WIDTH      (M_WIDTH),
    .PRESCALE_LOW (PRESCALE_LOW),
    .DIRECT_M_BITS(DIRECT_M_BITS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .divM      (divM),
    .directMode(directMode),
    .preDone   (preDone),
    .lastTick  (lastTick)
  );

endmodule

// File: tb/pulse_swallow_divider_bench.sv
`timescale 1ns/1ps
module pulse_swallow_divider_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] divM = 9'd20;
  logic [3:0] swallowA = 4'd5;
  logic       bypassPre = 1'b0;
  logic       directMode = 1'b0;
  logic       fpOut;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rstN(rstN), .divM(divM), .swallowA(swallowA),
    .bypassPre(bypassPre), .directMode(directMode), .fpOut(fpOut)
  );

  function automatic int expN(int m, int a, bit byp, bit dir);
    int me;
    me = dir ? (m % 128) : m;
    return byp ? (me + 1) : (10 * (me + 1) + a);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Behavioural reference: position within the division cycle
  bit modelLoad = 1'b1;
  bit fpExp = 1'b0;
  int pos = 0;
  int nCur = 1;
  always @(posedge clk) begin
    if (!rstN) begin
      modelLoad = 1'b1;
      fpExp = 1'b0;
      pos = 0;
    end else begin
      if (modelLoad || fpExp) begin
        nCur = expN(int'(divM), int'(swallowA), bypassPre, directMode);
        pos = 1;
        modelLoad = 1'b0;
      end else begin
        pos++;
      end
      fpExp = (pos == nCur);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done)
      check(fpOut == fpExp, {curReq, " per-clock model"}, int'(fpOut), int'(fpExp));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finishRun();
    end
  end

  task automatic waitPulse(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!fpOut);
  endtask

  // Apply settings, let the running cycle end, then measure two cycles
  task automatic measure(int m, int a, bit byp, bit dir, string req);
    int g;
    int e;
    curReq = req;
    divM = 9'(m); swallowA = 4'(a); bypassPre = byp; directMode = dir;
    waitPulse(g);
    e = expN(m, a, byp, dir);
    waitPulse(g);
    check(g == e, req, g, e);
    waitPulse(g);
    check(g == e, req, g, e);
  endtask

  initial begin
    int g;
    repeat (5) @(negedge clk);
    check(fpOut == 1'b0, "R1 reset low", int'(fpOut), 0);
    rstN = 1'b1;
    waitPulse(g);
    check(g == 215, "R1 first pulse", g, 215);
    @(negedge clk);
    check(fpOut == 1'b0, "R7 width", int'(fpOut), 0);
    waitPulse(g);
    check(g == 214, "R7 gap after pulse", g, 214);

    measure(20, 5, 0, 0, "R2");
    measure(300, 7, 0, 0, "R2");
    measure(30, 0, 0, 0, "R3 A zero");
    measure(14, 15, 0, 0, "R3 A max");
    measure(3, 4, 0, 0, "R3 A=M+1");
    measure(1, 0, 0, 0, "R5 normal");
    measure(1, 2, 0, 0, "R5 normal");
    measure(1, 0, 1, 0, "R5 bypass");
    measure(100, 3, 1, 0, "R4");
    measure(511, 0, 1, 0, "R4 max");
    measure(50, 0, 1, 0, "R9 A=0");
    measure(50, 15, 1, 0, "R9 A=15");
    measure(421, 3, 0, 1, "R6 normal");
    measure(200, 9, 1, 1, "R6 bypass");
    measure(127, 15, 0, 1, "R6 max");

    // R8: change settings in mid-cycle
    measure(20, 5, 0, 0, "R8 setup");
    curReq = "R8";
    repeat (30) @(negedge clk);
    divM = 9'd4; swallowA = 4'd1;
    waitPulse(g);
    check(g + 30 == 215, "R8 running cycle kept", g + 30, 215);
    waitPulse(g);
    check(g == 51, "R8 new settings", g, 51);

    for (int i = 0; i < 14; i++) begin
      int m, a, me;
      bit byp, dir;
      byp = (i % 3 == 0);
      dir = (i % 2 == 1);
      if (dir) begin
        m = int'($urandom % 511) + 1;
        if ((m % 128) == 0) m = m + 1;
        me = m % 128;
      end else begin
        m = byp ? int'($urandom % 511) + 1 : int'($urandom % 120) + 1;
        me = m;
      end
      a = int'($urandom % ((me + 2) < 16 ? (me + 2) : 16));
      measure(m, a, byp, dir, byp ? "R4 random" : "R2 random");
    end

    finishRun();
  end

endmodule